// File: doc/BRIEF.md
# Five-Port Mesh Tile Router with Outbound Link Protection

This block moves packets between one tile and its four mesh neighbours. Each of the five ports (north, south, east, west, local) has a 32-bit receive link and a 32-bit transmit link. A packet opens with a header word that gives the destination column, the destination row and the number of payload words that follow. The router reads the header at the head of each input queue and picks an output by dimension order. It then holds that output for exactly the header and the announced payload words, so packets never interleave on a link.

Every link uses credits. An input returns one credit pulse upstream for each word it removes from its 4-entry queue. An output only sends while it holds a credit from the downstream queue, so no word is ever lost. Software can fence off any outbound link with a per-link protection bit. A packet whose route would leave the tile over a fenced link is removed from its input and thrown away, not forwarded, and a sticky interrupt flag is set. That flag stays set until software pulses the clear input.

Top module: `mesh_router`

## Requirements
- R1: Header word layout: bits [7:0] give the payload length (0 to 128 words), bits [11:8] the destination column, bits [15:12] the destination row; bits [31:16] are ignored by routing and carried through unchanged.
- R2: Port index encoding is 0 north, 1 south, 2 east, 3 west, 4 local. With the tile at column 1, row 1, a header leaves on east if its column is larger, on west if smaller. Otherwise it leaves on south if its row is larger, on north if smaller, and on local if both match.
- R3: An output carries a packet as one unbroken run of the header followed by exactly its payload words, in order, even when several inputs compete for it. A zero-length packet is the header alone.
- R4: An output asserts valid only while it holds a downstream credit. It starts with 4 credits and gains one per credit pulse, so a stalled downstream sees at most 4 words, and the rest follow once credits return.
- R5: Each input pulses its credit line once for every word it accepts, so after traffic stops the upstream count returns to 4.
- R6: A packet routed onto an outbound link whose protection bit is set never appears on that link. All of its words are still accepted and credited, and the next packet from the same input is routed normally.
- R7: The interrupt goes high in the cycle after a packet is blocked. It stays high until the clear input is pulsed, and a blocked packet in the same cycle as a clear wins.
- R8: Protection acts only on traffic leaving the tile: a packet arriving on a fenced port, or one leaving through an unfenced port, is delivered and raises no interrupt.
- R9: After reset, no output is valid, no credit pulse is given and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 5 | Word present on each receive link |
| rx_data | input | 5x32 | Receive link words, one per port |
| rx_credit | output | 5 | One-cycle credit pulse to each upstream sender |
| tx_valid | output | 5 | Word present on each transmit link |
| tx_data | output | 5x32 | Transmit link words, one per port |
| tx_credit | input | 5 | One-cycle credit pulse from each downstream receiver |
| wall_en | input | 5 | Protection bit for each transmit link |
| irq_clear | input | 1 | Clears the interrupt flag |
| irq | output | 1 | Sticky blocked-traffic interrupt |

## Verification
Routing is swept over every destination in the 3x3 neighbourhood from every input, one packet at a time, with lengths that include zero. This separates the column-first choice from the row choice and the local case. Two contention patterns follow: all five inputs aimed at the same output, which shows whether lock and arbitration keep packets whole, and five inputs aimed at five different outputs, which shows that parallel paths do not disturb each other. A maximum-length packet and a run with downstream credits withheld test the length counter and the credit stall. Protection patterns block one link and then send through a different link, into the fenced port and again after the fence is lifted, so that outbound-only blocking shows up apart from the interrupt.

// File: rtl/router_pkg.sv
// Package: shared constants for the mesh tile router.
// Assumes a five-port tile; port indices are fixed because routing depends on them.
package router_pkg;
    localparam int NPORT = 5;
    localparam int PW    = 3;
    localparam int P_N   = 0;
    localparam int P_S   = 1;
    localparam int P_E   = 2;
    localparam int P_W   = 3;
    localparam int P_L   = 4;
endpackage

// File: rtl/rt_in_fifo.sv
// Module: small receive queue for one input link.
// Assumes the upstream sender respects credits; a push into a full queue is refused.
module rt_in_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Storage write: data array needs no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rt_route_calc.sv
// Module: dimension-ordered output choice for one header.
// Assumes column is resolved before row; one-hot result indexed by router_pkg ports.
module rt_route_calc
    import router_pkg::*;
#(
    parameter int COORD_W = 4,
    parameter int TILE_X  = 1,
    parameter int TILE_Y  = 1
) (
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output logic [NPORT-1:0]   dir
);
    localparam logic [COORD_W-1:0] HX = COORD_W'(TILE_X);
    localparam logic [COORD_W-1:0] HY = COORD_W'(TILE_Y);

    // Column first, then row, then deliver locally.
    always_comb begin
        dir = '0;
        if (dst_x > HX)      dir[P_E] = 1'b1;
        else if (dst_x < HX) dir[P_W] = 1'b1;
        else if (dst_y > HY) dir[P_S] = 1'b1;
        else if (dst_y < HY) dir[P_N] = 1'b1;
        else                 dir[P_L] = 1'b1;
    end
endmodule

// File: rtl/rt_in_port.sv
// Module: one input unit - queue, header tracking, route, protection drain, credit return.
// Assumes a word count of zero means the queue head is a header; body words
// are popped either by the owning output or by the drain path of a blocked packet.
module rt_in_port
    import router_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int COORD_W = 4,
    parameter int LEN_W   = 8,
    parameter int DEPTH   = 4,
    parameter int TILE_X  = 1,
    parameter int TILE_Y  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lnk_valid,
    input  logic [DATA_W-1:0] lnk_data,
    input  logic [NPORT-1:0]  wall_en,
    input  logic              fwd_pop,
    output logic [DATA_W-1:0] head_data,
    output logic              has_word,
    output logic              hdr_req,
    output logic [NPORT-1:0]  route,
    output logic              wall_hit,
    output logic              credit_ret
);
    logic             empty, full;
    logic [LEN_W-1:0] rem_q;
    logic             drop_q;
    logic             head_is_hdr, walled, drain, pop;
    logic [LEN_W-1:0] hdr_len;

    rt_in_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (lnk_valid),
        .wdata (lnk_data),
        .pop   (pop),
        .rdata (head_data),
        .empty (empty),
        .full  (full)
    );

    rt_route_calc #(.COORD_W(COORD_W), .TILE_X(TILE_X), .TILE_Y(TILE_Y)) route_i (
        .dst_x (head_data[LEN_W +: COORD_W]),
        .dst_y (head_data[LEN_W + COORD_W +: COORD_W]),
        .dir   (route)
    );

    assign has_word    = !empty;
    assign hdr_len     = head_data[LEN_W-1:0];
    assign head_is_hdr = has_word && (rem_q == '0);
    assign walled      = |(route & wall_en);
    assign hdr_req     = head_is_hdr && !walled;
    assign wall_hit    = head_is_hdr && walled;
    assign drain       = has_word && (wall_hit || drop_q);
    assign pop         = fwd_pop || drain;

    // Track words left in the current packet and whether it is being discarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            drop_q <= 1'b0;
        end else if (pop) begin
            if (rem_q == '0) begin
                rem_q  <= hdr_len;
                drop_q <= walled && (hdr_len != '0);
            end else begin
                rem_q <= rem_q - 1'b1;
                if (rem_q == LEN_W'(1)) drop_q <= 1'b0;
            end
        end
    end

    // One credit pulse upstream per word removed.
    always_ff @(posedge clk) begin
        if (!rst_n) credit_ret <= 1'b0;
        else        credit_ret <= pop;
    end
endmodule

// File: rtl/rt_out_port.sv
// Module: one output unit - round-robin header grant, wormhole lock, credit counter.
// Assumes at most one header grant per cycle; the lock lasts for the announced payload.
module rt_out_port
    import router_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 8,
    parameter int CRED_MAX = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT-1:0]              req,
    input  logic [NPORT-1:0]              has_word,
    input  logic [NPORT-1:0][DATA_W-1:0]  head_data,
    input  logic                          lnk_credit,
    output logic [NPORT-1:0]              take,
    output logic                          lnk_valid,
    output logic [DATA_W-1:0]             lnk_data
);
    localparam int CRW = $clog2(CRED_MAX + 1);

    logic             locked_q;
    logic [PW-1:0]    owner_q, last_q, pick, sel;
    logic [LEN_W-1:0] rem_q, hdr_len;
    logic [CRW-1:0]   cred_q;
    logic             found, fire;
    int               cand;

    // Round-robin search starting after the last granted input.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        cand  = 0;
        for (int k = 1; k <= NPORT; k++) begin
            cand = int'(last_q) + k;
            if (cand >= NPORT) cand = cand - NPORT;
            if (!found && req[cand]) begin
                found = 1'b1;
                pick  = PW'(cand);
            end
        end
    end

    assign sel     = locked_q ? owner_q : pick;
    assign hdr_len = head_data[sel][LEN_W-1:0];
    assign fire    = (cred_q != '0) && (locked_q ? has_word[owner_q] : found);

    // Pop strobe to the selected input.
    always_comb begin
        take = '0;
        if (fire) take[sel] = 1'b1;
    end

    // Lock, owner and payload countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            owner_q  <= '0;
            last_q   <= PW'(NPORT - 1);
            rem_q    <= '0;
        end else if (fire) begin
            if (!locked_q) begin
                last_q <= sel;
                if (hdr_len != '0) begin
                    locked_q <= 1'b1;
                    owner_q  <= sel;
                    rem_q    <= hdr_len;
                end
            end else begin
                rem_q <= rem_q - 1'b1;
                if (rem_q == LEN_W'(1)) locked_q <= 1'b0;
            end
        end
    end

    // Downstream credit count.
    always_ff @(posedge clk) begin
        if (!rst_n) cred_q <= CRW'(CRED_MAX);
        else case ({fire, lnk_credit})
            2'b10:   cred_q <= cred_q - 1'b1;
            2'b01:   cred_q <= cred_q + 1'b1;
            default: cred_q <= cred_q;
        endcase
    end

    // Registered link output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lnk_valid <= 1'b0;
            lnk_data  <= '0;
        end else begin
            lnk_valid <= fire;
            if (fire) lnk_data <= head_data[sel];
        end
    end
endmodule

// File: rtl/mesh_router.sv
// Module: five-port mesh tile router, top level.
// Assumes neighbours have queues of FIFO_DEPTH words; interrupt is set on any blocked header.
module mesh_router
    import router_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int COORD_W    = 4,
    parameter int LEN_W      = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int TILE_X     = 1,
    parameter int TILE_Y     = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             rx_valid,
    input  logic [NPORT-1:0][DATA_W-1:0] rx_data,
    output logic [NPORT-1:0]             rx_credit,
    output logic [NPORT-1:0]             tx_valid,
    output logic [NPORT-1:0][DATA_W-1:0] tx_data,
    input  logic [NPORT-1:0]             tx_credit,
    input  logic [NPORT-1:0]             wall_en,
    input  logic                         irq_clear,
    output logic                         irq
);
    logic [NPORT-1:0][DATA_W-1:0] head_data;
    logic [NPORT-1:0]             has_word, hdr_req, wall_hit, fwd_pop;
    logic [NPORT-1:0][NPORT-1:0]  route;   // [input][output]
    logic [NPORT-1:0][NPORT-1:0]  req_m;   // [output][input]
    logic [NPORT-1:0][NPORT-1:0]  take_m;  // [output][input]
    logic                         irq_q;

    for (genvar i = 0; i < NPORT; i++) begin : gen_in
        rt_in_port #(
            .DATA_W(DATA_W), .COORD_W(COORD_W), .LEN_W(LEN_W),
            .DEPTH(FIFO_DEPTH), .TILE_X(TILE_X), .TILE_Y(TILE_Y)
        ) in_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .lnk_valid  (rx_valid[i]),
            .lnk_data   (rx_data[i]),
            .wall_en    (wall_en),
            .fwd_pop    (fwd_pop[i]),
            .head_data  (head_data[i]),
            .has_word   (has_word[i]),
            .hdr_req    (hdr_req[i]),
            .route      (route[i]),
            .wall_hit   (wall_hit[i]),
            .credit_ret (rx_credit[i])
        );
    end

    // Cross the per-input route into per-output requests; gather pops per input.
    always_comb begin
        for (int o = 0; o < NPORT; o++)
            for (int i = 0; i < NPORT; i++)
                req_m[o][i] = hdr_req[i] && route[i][o];
        for (int i = 0; i < NPORT; i++) begin
            fwd_pop[i] = 1'b0;
            for (int o = 0; o < NPORT; o++) fwd_pop[i] = fwd_pop[i] | take_m[o][i];
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : gen_out
        rt_out_port #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CRED_MAX(FIFO_DEPTH)) out_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (req_m[o]),
            .has_word   (has_word),
            .head_data  (head_data),
            .lnk_credit (tx_credit[o]),
            .take       (take_m[o]),
            .lnk_valid  (tx_valid[o]),
            .lnk_data   (tx_data[o])
        );
    end

    // Sticky interrupt: a blocked header sets it, software clear drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (|wall_hit) irq_q <= 1'b1;
        else if (irq_clear) irq_q <= 1'b0;
    end

    assign irq = irq_q;
endmodule

// File: rtl/mesh_router_chk.sv
// Module: property checker for mesh_router, attached by bind.
// Assumes downstream queues of CRED_MAX words, matching the router's own credit start.
module mesh_router_chk
    import router_pkg::*;
#(
    parameter int CRED_MAX = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NPORT-1:0]            tx_valid,
    input logic [NPORT-1:0]            tx_credit,
    input logic                        irq,
    input logic                        irq_clear,
    input logic [NPORT-1:0]            wall_hit,
    input logic [NPORT-1:0][NPORT-1:0] take_m
);
    localparam int CW = $clog2(CRED_MAX + 2);

    for (genvar o = 0; o < NPORT; o++) begin : gen_oc
        logic [CW-1:0] seen;
        // Independent credit count built from the link signals only.
        always_ff @(posedge clk) begin
            if (!rst_n) seen <= CW'(CRED_MAX);
            else case ({tx_valid[o], tx_credit[o]})
                2'b10:   seen <= seen - 1'b1;
                2'b01:   seen <= seen + 1'b1;
                default: seen <= seen;
            endcase
        end
        AST_TX_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n) tx_valid[o] |-> (seen != '0)); // R4
    end

    for (genvar i = 0; i < NPORT; i++) begin : gen_ic
        logic [NPORT-1:0] takers;
        always_comb for (int o = 0; o < NPORT; o++) takers[o] = take_m[o][i];
        AST_SINGLE_TAKER: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(takers)); // R3
    end

    AST_WALL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (|wall_hit) |=> irq); // R7
    AST_IRQ_STICKY:      assert property (@(posedge clk) disable iff (!rst_n) (irq && !irq_clear) |=> irq); // R7
    AST_IRQ_QUIET:       assert property (@(posedge clk) disable iff (!rst_n) (!irq && !(|wall_hit)) |=> !irq); // R7
endmodule

bind mesh_router mesh_router_chk #(.CRED_MAX(FIFO_DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_credit (tx_credit),
    .irq       (irq),
    .irq_clear (irq_clear),
    .wall_hit  (wall_hit),
    .take_m    (take_m)
);

// File: tb/mesh_router_tb_top.sv
// Bench: routing sweep, contention, credit stall and protection checks for mesh_router.
module mesh_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int DEPTH = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NP-1:0]           rxv = '0;
    logic [NP-1:0][31:0]     rxd = '0;
    logic [NP-1:0]           rxc;
    logic [NP-1:0]           txv;
    logic [NP-1:0][31:0]     txd;
    logic [NP-1:0]           txc = '0;
    logic [NP-1:0]           wall = '0;
    logic                    irq_clear = 1'b0;
    logic                    irq;

    int cred [NP];
    int owed [NP];
    bit hold [NP];
    int mon_rem [NP];
    int mon_tag [NP];
    int mon_idx [NP];
    bit mon_ok [NP];
    int pkts [NP];
    int words [NP];
    int exp_pkts [NP];
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int tag_n = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesh_router dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rxv), .rx_data(rxd), .rx_credit(rxc),
        .tx_valid(txv), .tx_data(txd), .tx_credit(txc), .wall_en(wall),
        .irq_clear(irq_clear), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected output port for the tile at column 1, row 1.
    function automatic int exp_port(input int dx, input int dy);
        if (dx > 1) return 2;
        if (dx < 1) return 3;
        if (dy > 1) return 1;
        if (dy < 1) return 0;
        return 4;
    endfunction

    // Upstream credit bookkeeping.
    always @(posedge clk) begin
        for (int p = 0; p < NP; p++)
            if (!rst_n) cred[p] <= DEPTH;
            else        cred[p] <= cred[p] + int'(rxc[p]) - int'(rxv[p]);
    end

    // Output monitor and downstream credit return.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int o = 0; o < NP; o++) begin
                owed[o] = 0; mon_rem[o] = 0; pkts[o] = 0; words[o] = 0; txc[o] = 1'b0;
            end
        end else begin
            for (int o = 0; o < NP; o++) begin
                if (txv[o]) begin
                    words[o]++;
                    if (mon_rem[o] == 0) begin
                        mon_tag[o] = int'(txd[o][31:16]);
                        chk(o == exp_port(int'(txd[o][11:8]), int'(txd[o][15:12])), "R2 route", o,
                            exp_port(int'(txd[o][11:8]), int'(txd[o][15:12])));
                        if (txd[o][7:0] == 8'd0) pkts[o]++;
                        else begin
                            mon_rem[o] = int'(txd[o][7:0]); mon_idx[o] = 0; mon_ok[o] = 1'b1;
                        end
                    end else begin
                        if (txd[o] != {mon_tag[o][15:0], mon_idx[o][15:0]}) mon_ok[o] = 1'b0;
                        mon_idx[o]++;
                        mon_rem[o]--;
                        if (mon_rem[o] == 0) begin
                            chk(mon_ok[o], "R3 R1 body intact", int'(mon_ok[o]), 1);
                            pkts[o]++;
                        end
                    end
                    owed[o]++;
                end
                if (!hold[o] && owed[o] > 0) begin
                    txc[o] = 1'b1; owed[o]--;
                end else txc[o] = 1'b0;
            end
        end
    end

    task automatic send_word(input int p, input logic [31:0] w);
        while (cred[p] == 0) @(negedge clk);
        rxv[p] = 1'b1;
        rxd[p] = w;
        @(negedge clk);
        rxv[p] = 1'b0;
    endtask

    task automatic send_pkt(input int p, input int dx, input int dy, input int len, input bit expect_out);
        int tag;
        tag = tag_n;
        tag_n++;
        if (expect_out) exp_pkts[exp_port(dx, dy)]++;
        send_word(p, {tag[15:0], 4'(dy), 4'(dx), 8'(len)});
        for (int k = 0; k < len; k++) send_word(p, {tag[15:0], 16'(k)});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

    initial begin
        int w0, p0;
        for (int o = 0; o < NP; o++) begin exp_pkts[o] = 0; hold[o] = 1'b0; end
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(txv == '0, "R9 tx_valid", int'(txv), 0);
        chk(rxc == '0, "R9 rx_credit", int'(rxc), 0);
        chk(irq == 1'b0, "R9 irq", int'(irq), 0);

        // R2 R1: sweep every source over the 3x3 neighbourhood, lengths include 0
        for (int p = 0; p < NP; p++)
            for (int dx = 0; dx < 3; dx++)
                for (int dy = 0; dy < 3; dy++)
                    send_pkt(p, dx, dy, (p * 3 + dx + 2 * dy) % 6, 1'b1);
        idle(30);
        for (int o = 0; o < NP; o++) chk(pkts[o] == exp_pkts[o], "R3 sweep packet count", pkts[o], exp_pkts[o]);
        for (int p = 0; p < NP; p++) chk(cred[p] == DEPTH, "R5 credits restored", cred[p], DEPTH);

        // R3: all inputs contend for east
        for (int r = 0; r < 2; r++) begin
            fork
                send_pkt(0, 2, 1, 5, 1'b1);
                send_pkt(1, 2, 0, 3, 1'b1);
                send_pkt(2, 2, 2, 6, 1'b1);
                send_pkt(3, 2, 1, 0, 1'b1);
                send_pkt(4, 2, 1, 4, 1'b1);
            join
        end
        // distinct outputs in parallel
        fork
            send_pkt(0, 0, 1, 4, 1'b1);
            send_pkt(1, 2, 1, 4, 1'b1);
            send_pkt(2, 1, 0, 4, 1'b1);
            send_pkt(3, 1, 2, 4, 1'b1);
            send_pkt(4, 1, 1, 4, 1'b1);
        join
        // R1: maximum payload
        send_pkt(3, 2, 1, 128, 1'b1);
        idle(30);
        for (int o = 0; o < NP; o++) chk(pkts[o] == exp_pkts[o], "R3 contention packet count", pkts[o], exp_pkts[o]);

        // R4: downstream withholds credits on local
        hold[4] = 1'b1;
        w0 = words[4];
        p0 = pkts[4];
        fork
            send_pkt(0, 1, 1, 8, 1'b1);
            begin
                idle(40);
                chk(words[4] - w0 == DEPTH, "R4 stall at credit limit", words[4] - w0, DEPTH);
                hold[4] = 1'b0;
            end
        join
        idle(30);
        chk(pkts[4] == p0 + 1, "R4 stalled packet completes", pkts[4], p0 + 1);
        chk(words[4] - w0 == 9, "R4 no word lost", words[4] - w0, 9);

        // R6 R7: block east, send local -> east-bound
        wall[2] = 1'b1;
        w0 = words[2];
        send_pkt(4, 2, 0, 3, 1'b0);
        idle(20);
        chk(words[2] == w0, "R6 nothing on walled link", words[2] - w0, 0);
        chk(cred[4] == DEPTH, "R6 blocked packet drained", cred[4], DEPTH);
        chk(irq == 1'b1, "R7 irq raised", int'(irq), 1);
        // R6: same input continues normally; R7 flag holds
        send_pkt(4, 0, 1, 2, 1'b1);
        idle(20);
        chk(pkts[3] == exp_pkts[3], "R6 next packet delivered", pkts[3], exp_pkts[3]);
        chk(irq == 1'b1, "R7 irq sticky", int'(irq), 1);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R7 irq cleared", int'(irq), 0);
        // R8: packet arriving on the fenced port, and one leaving elsewhere
        send_pkt(2, 1, 1, 2, 1'b1);
        send_pkt(0, 1, 2, 3, 1'b1);
        idle(20);
        chk(pkts[4] == exp_pkts[4], "R8 inbound on fenced port delivered", pkts[4], exp_pkts[4]);
        chk(pkts[1] == exp_pkts[1], "R8 other link delivered", pkts[1], exp_pkts[1]);
        chk(irq == 1'b0, "R8 no irq for allowed traffic", int'(irq), 0);
        // R6: lift the fence
        wall[2] = 1'b0;
        send_pkt(4, 2, 0, 3, 1'b1);
        idle(20);
        chk(pkts[2] == exp_pkts[2], "R6 link open again", pkts[2], exp_pkts[2]);
        chk(irq == 1'b0, "R7 irq stays low", int'(irq), 0);

        for (int o = 0; o < NP; o++) chk(pkts[o] == exp_pkts[o], "R3 final packet count", pkts[o], exp_pkts[o]);
        for (int p = 0; p < NP; p++) chk(cred[p] == DEPTH, "R5 final credits", cred[p], DEPTH);
        for (int o = 0; o < NP; o++) chk(mon_rem[o] == 0, "R1 no partial packet", mon_rem[o], 0);
        finish_run();
    end
endmodule